// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

This block is a 32-pin general-purpose I/O port that sits behind a simple memory-mapped register interface. Software drives the output pins through a data-output register. It can replace the whole register in one write, or it can use three alias addresses that force selected bits high, force them low or invert them. A bit written as zero through an alias leaves that output bit as it was. Software reads the pin levels through a read-only register. The pins reach that register through a two-flop synchronizer.

Each pin has its own control word. A 4-bit interrupt mode in that word makes the pin raise a flag while its level is high or low, or on a rising, falling or either edge. The flags are collected in one shared status word, and writing a one to a bit of that word clears the flag. One interrupt output is high while any flag is pending. The address space has two halves. Address bit 8 clear selects the control side: the per-pin control words and the status word. Address bit 8 set selects the data side: output, aliases and input. All accesses are 32-bit and word aligned. Read data is combinational from the address while a read is selected.

Top module: `gpio_irq_port`

## Requirements
- R1: Reset clears the output register, every control word and every status flag. While those registers are clear, the interrupt output is low.
- R2: A write to address 0x100 replaces the output register with the written value, and a read of 0x100 returns that value. Bit n of every data and status word belongs to pin n.
- R3: Writes to 0x104, 0x108 and 0x10C set, clear and invert, in that order, each output bit written as 1, and leave bits written as 0 unchanged. The new value appears on the output pins after the clock edge that samples the write strobe, not before.
- R4: A read of 0x110 returns the pin levels two clock edges after they change, and writes to 0x110 are ignored.
- R5: The control word of pin n is at address 4*n and keeps its interrupt mode in bits 19:16. Those bits read back as written, and every other bit of the word reads as zero.
- R6: Mode 0x9 flags a rising edge, 0xA a falling edge and 0xB either edge. An edge is a change of the synchronized level between two consecutive cycles.
- R7: Mode 0x8 flags the pin while it is low and mode 0xC while it is high. In those modes a clear does not remove the flag while the level is still present.
- R8: Writing to the status word at 0x0A0 clears each flag written as 1 and leaves flags written as 0 pending. Writing all ones clears every flag.
- R9: When a new event and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: Mode 0x0, and any code not listed in R6 or R7, never sets a flag. Writing 0 to a control word therefore masks that pin.
- R11: The interrupt output is high in exactly the cycles in which at least one status flag is set.
- R12: A read of any address that is not mapped, or not word aligned, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address; bit 8 selects the data side |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a selected read |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_o | output | 32 | Output register value driven to the pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a new edge arriving in the same cycle as a software clear of the same flag. The edge is seen only after the synchronizer delay, so the bench counts edges: it changes the pin on a falling clock edge and places the status write exactly two cycles later, when the detector reports the event. It sets the flag beforehand so that a lost set would be visible. Level-mode clears are tested in a similar way: a clear is issued while the level is held, and the flag must still read as set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [3:0] {
    IRQ_OFF  = 4'h0,
    IRQ_LOW  = 4'h8,
    IRQ_RISE = 4'h9,
    IRQ_FALL = 4'hA,
    IRQ_BOTH = 4'hB,
    IRQ_HIGH = 4'hC
  } irq_mode_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_SET,
    OP_CLR,
    OP_TGL
  } out_op_e;

  // Event for one pin from its mode, current and previous synchronized level.
  function automatic logic pin_event(input logic [3:0] mode, input logic cur,
                                     input logic prev);
    logic hit;
    case (mode)
      IRQ_LOW:  hit = ~cur;
      IRQ_RISE: hit = cur & ~prev;
      IRQ_FALL: hit = ~cur & prev;
      IRQ_BOTH: hit = cur ^ prev;
      IRQ_HIGH: hit = cur;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Next value of one output bit for a given write operation.
  function automatic logic alias_bit(input out_op_e op, input logic old,
                                     input logic m);
    logic nxt;
    case (op)
      OP_LOAD: nxt = m;
      OP_SET:  nxt = old | m;
      OP_CLR:  nxt = old & ~m;
      OP_TGL:  nxt = old ^ m;
      default: nxt = old;
    endcase
    return nxt;
  endfunction

  // Write-one-to-clear flag where a new event has priority over the clear.
  function automatic logic flag_next(input logic cur, input logic clr,
                                     input logic evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);

  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prev_o <= '0;
    end else begin
      stg[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev_o <= stg[STAGES-1];
    end
  end

  assign cur_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  out_op_e      op_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] dout_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_o[g] <= 1'b0;
      else        dout_o[g] <= alias_bit(op_i, dout_o[g], mask_i[g]);
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int MW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cur_i,
  input  logic [N-1:0]    prev_i,
  input  logic [MW*N-1:0] mode_i,
  input  logic            clr_we_i,
  input  logic [N-1:0]    clr_mask_i,
  output logic [N-1:0]    evt_o,
  output logic [N-1:0]    sts_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign evt_o[g] = pin_event(mode_i[g*MW +: MW], cur_i[g], prev_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_o[g] <= 1'b0;
      else        sts_o[g] <= flag_next(sts_o[g], clr_we_i & clr_mask_i[g], evt_o[g]);
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_LSB    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic              irq_o
);

  localparam int MW     = 4;
  localparam int OFF_W  = ADDR_W - 1;
  localparam int IDX_W  = OFF_W - 2;
  localparam logic [OFF_W-1:0] OFF_STS  = OFF_W'(8'hA0);
  localparam logic [OFF_W-1:0] OFF_DOUT = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] OFF_SET  = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] OFF_CLR  = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] OFF_TGL  = OFF_W'(8'h0C);
  localparam logic [OFF_W-1:0] OFF_DIN  = OFF_W'(8'h10);
  localparam logic [OFF_W-1:0] CTRL_END = OFF_W'(4 * NPINS);

  // ---------------- decode ----------------
  logic              data_side;
  logic              aligned;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  ctrl_idx;
  logic              ctrl_hit;
  logic              wr_hit;
  logic              rd_hit;
  logic [NPINS-1:0]  wmask;

  assign data_side = bus_addr[ADDR_W-1];
  assign off       = bus_addr[OFF_W-1:0];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign ctrl_idx  = off[OFF_W-1:2];
  assign ctrl_hit  = !data_side && aligned && (off < CTRL_END);
  assign wr_hit    = bus_sel && bus_wr && aligned;
  assign rd_hit    = bus_sel && !bus_wr && aligned;
  assign wmask     = bus_wdata[NPINS-1:0];

  // Named write events, also observed by the checker.
  logic sts_clr_we;
  logic set_we;
  logic clr_we;
  logic tgl_we;
  logic load_we;

  assign sts_clr_we = wr_hit && !data_side && (off == OFF_STS);
  assign load_we    = wr_hit && data_side && (off == OFF_DOUT);
  assign set_we     = wr_hit && data_side && (off == OFF_SET);
  assign clr_we     = wr_hit && data_side && (off == OFF_CLR);
  assign tgl_we     = wr_hit && data_side && (off == OFF_TGL);

  out_op_e out_op;
  always_comb begin
    out_op = OP_NONE;
    if (load_we)     out_op = OP_LOAD;
    else if (set_we) out_op = OP_SET;
    else if (clr_we) out_op = OP_CLR;
    else if (tgl_we) out_op = OP_TGL;
  end

  // ---------------- output register ----------------
  gpio_out_reg #(.N(NPINS)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (out_op),
    .mask_i (wmask),
    .dout_o (pin_o)
  );

  // ---------------- input synchronizer ----------------
  logic [NPINS-1:0] pin_cur;
  logic [NPINS-1:0] pin_prev;

  gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  // ---------------- per-pin control words ----------------
  logic [MW*NPINS-1:0] mode_flat;

  for (genvar g = 0; g < NPINS; g++) begin : g_ctrl
    logic [MW-1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_q <= '0;
      else if (wr_hit && ctrl_hit && (ctrl_idx == IDX_W'(g)))
        mode_q <= bus_wdata[MODE_LSB +: MW];
    end
    assign mode_flat[g*MW +: MW] = mode_q;
  end

  // ---------------- detection and status ----------------
  logic [NPINS-1:0] evt_vec;
  logic [NPINS-1:0] sts_q;

  gpio_irq_detect #(.N(NPINS), .MW(MW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_i      (pin_cur),
    .prev_i     (pin_prev),
    .mode_i     (mode_flat),
    .clr_we_i   (sts_clr_we),
    .clr_mask_i (wmask),
    .evt_o      (evt_vec),
    .sts_o      (sts_q)
  );

  assign irq_o = |sts_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (data_side) begin
        if (off == OFF_DOUT)     bus_rdata[NPINS-1:0] = pin_o;
        else if (off == OFF_DIN) bus_rdata[NPINS-1:0] = pin_cur;
      end else if (off == OFF_STS) begin
        bus_rdata[NPINS-1:0] = sts_q;
      end else if (ctrl_hit) begin
        for (int i = 0; i < NPINS; i++)
          if (ctrl_idx == IDX_W'(i))
            bus_rdata[MODE_LSB +: MW] = mode_flat[i*MW +: MW];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_o,
  input logic [N-1:0] evt_vec,
  input logic [N-1:0] sts_q,
  input logic         sts_clr_we,
  input logic         set_we,
  input logic         clr_we,
  input logic [N-1:0] mask,
  input logic [N-1:0] dout
);

  // R6 / R11: the interrupt line only rises after the detector reported an event
  p_rise_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|evt_vec));

  // R8 / R11: the interrupt line only drops after a status clear
  p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(sts_clr_we));

  // R9: an event in the clear cycle leaves its flag set
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_we |=> ((sts_q & $past(evt_vec)) == $past(evt_vec)));

  // R3: set alias drives every masked bit high
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((dout & $past(mask)) == $past(mask)));

  // R3: clear alias drives every masked bit low
  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((dout & $past(mask)) == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .evt_vec    (evt_vec),
  .sts_q      (sts_q),
  .sts_clr_we (sts_clr_we),
  .set_we     (set_we),
  .clr_we     (clr_we),
  .mask       (wmask),
  .dout       (pin_o)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_i     (pin_i),
    .pin_o     (pin_o),
    .irq_o     (irq_o)
  );

  localparam logic [8:0] A_DOUT = 9'h100;
  localparam logic [8:0] A_SET  = 9'h104;
  localparam logic [8:0] A_CLR  = 9'h108;
  localparam logic [8:0] A_TGL  = 9'h10C;
  localparam logic [8:0] A_DIN  = 9'h110;
  localparam logic [8:0] A_STS  = 9'h0A0;

  // Output-register vectors: address, data, expected output afterwards.
  localparam int NV = 8;
  localparam logic [8:0]  VA [NV] = '{A_DOUT, A_SET, A_CLR, A_TGL, A_SET, A_CLR, A_TGL, A_DOUT};
  localparam logic [31:0] VD [NV] = '{32'hA5A5_0F0F, 32'h0000_F0F0, 32'hA5A5_0000, 32'hFFFF_0001,
                                      32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678};
  localparam logic [31:0] VE [NV] = '{32'hA5A5_0F0F, 32'hA5A5_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFE,
                                      32'hFFFF_FFFE, 32'h0000_0000, 32'h8000_0001, 32'h1234_5678};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_DOUT, d);    chk("R1 dout", d, 32'h0);
    rd(9'h00C, d);    chk("R1 ctrl3", d, 32'h0);
    rd(A_STS, d);     chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);

    // R2 / R3: vector walk over load and alias writes
    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      chk($sformatf("R2/R3 vec%0d pin_o", i), pin_o, VE[i]);
      rd(A_DOUT, d);
      chk($sformatf("R2 vec%0d readback", i), d, VE[i]);
    end

    // R3: new value appears only after the sampling edge
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_SET; bus_wdata = 32'h0000_0001;
    #1 chk("R3 before edge", pin_o, 32'h1234_5678);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R3 after edge", pin_o, 32'h1234_5679);

    // R4: two-edge synchronizer latency and write ignored
    @(negedge clk);
    pin_i = 32'hDEAD_BEEF;
    #1 peek(A_DIN, d); chk("R4 no edge yet", d, 32'h0);
    @(negedge clk);
    peek(A_DIN, d);    chk("R4 one edge", d, 32'h0);
    @(negedge clk);
    peek(A_DIN, d);    chk("R4 two edges", d, 32'hDEAD_BEEF);
    wr(A_DIN, 32'h0);
    rd(A_DIN, d);      chk("R4 write ignored", d, 32'hDEAD_BEEF);

    // R5: control word readback
    wr(9'h014, 32'hFFFF_FFFF);
    rd(9'h014, d);     chk("R5 ctrl5 field only", d, 32'h000F_0000);
    wr(9'h07C, 32'h0009_0000);
    rd(9'h07C, d);     chk("R5 ctrl31", d, 32'h0009_0000);
    wr(9'h014, 32'h0);
    wr(9'h07C, 32'h0);
    rd(A_STS, d);      chk("R10 no flags with modes off", d, 32'h0);

    // R6: edge modes (pin3 rise, pin4 fall, pin5 either)
    pin_i = 32'h0;
    cyc(4);
    wr(9'h00C, 32'h0009_0000);
    wr(9'h010, 32'h000A_0000);
    wr(9'h014, 32'h000B_0000);
    @(negedge clk); pin_i = 32'h0000_0038;
    cyc(4);
    rd(A_STS, d);      chk("R6 rising/either", d, 32'h0000_0028);
    chk("R11 irq high", {31'h0, irq_o}, 32'h1);
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, d);      chk("R8 clear all", d, 32'h0);
    chk("R11 irq low", {31'h0, irq_o}, 32'h0);
    @(negedge clk); pin_i = 32'h0;
    cyc(4);
    rd(A_STS, d);      chk("R6 falling/either", d, 32'h0000_0030);
    wr(A_STS, 32'h0000_0010);
    rd(A_STS, d);      chk("R8 partial clear", d, 32'h0000_0020);
    wr(A_STS, 32'hFFFF_FFFF);

    // R7: level modes (pin6 high, pin7 low)
    wr(9'h018, 32'h000C_0000);
    wr(9'h01C, 32'h0008_0000);
    cyc(3);
    rd(A_STS, d);      chk("R7 low level flagged", d, 32'h0000_0080);
    wr(A_STS, 32'h0000_0080);
    rd(A_STS, d);      chk("R7 clear while low", d, 32'h0000_0080);
    @(negedge clk); pin_i = 32'h0000_00C0;
    cyc(4);
    rd(A_STS, d);      chk("R7 high level flagged", d, 32'h0000_00C0);
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, d);      chk("R7 clear while high", d, 32'h0000_0040);
    @(negedge clk); pin_i = 32'h0000_0080;
    cyc(4);
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, d);      chk("R7 released", d, 32'h0);

    // R10: masked pin and unlisted code
    wr(9'h018, 32'h0);
    wr(9'h020, 32'h0001_0000);
    @(negedge clk); pin_i = 32'h0000_01C0;
    cyc(4);
    @(negedge clk); pin_i = 32'h0000_0080;
    cyc(4);
    rd(A_STS, d);      chk("R10 disabled pins", d, 32'h0);
    chk("R10 irq", {31'h0, irq_o}, 32'h0);

    // R9: new rising edge on pin3 lands in the clear cycle
    @(negedge clk); pin_i = 32'h0000_0088;
    cyc(4);
    @(negedge clk); pin_i = 32'h0000_0080;
    cyc(4);
    rd(A_STS, d);      chk("R9 preset", d, 32'h0000_0008);
    @(negedge clk); pin_i = 32'h0000_0088;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    peek(A_STS, d);    chk("R9 set wins", d, 32'h0000_0008);
    wr(A_STS, 32'h0000_0008);
    rd(A_STS, d);      chk("R8 clear without event", d, 32'h0);

    // R12: unmapped and misaligned reads
    rd(9'h0A4, d);     chk("R12 0x0A4", d, 32'h0);
    rd(9'h114, d);     chk("R12 0x114", d, 32'h0);
    rd(9'h1FC, d);     chk("R12 0x1FC", d, 32'h0);
    rd(9'h101, d);     chk("R12 misaligned", d, 32'h0);

    // R1: reset in the middle of operation
    wr(A_DOUT, 32'h0000_FFFF);
    @(negedge clk); pin_i = 32'h0000_0000;
    cyc(4);
    rd(A_STS, d);      chk("R7 pre-reset flag", d, 32'h0000_0080);
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    chk("R1 pin_o after reset", pin_o, 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    rd(9'h01C, d);     chk("R1 ctrl7 after reset", d, 32'h0);
    rd(A_STS, d);      chk("R1 status after reset", d, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule